// File: doc/BRIEF.md
# Fall-Through Handshake FIFO with Occupancy Flags

This block is a first-in/first-out buffer of 64 words of 5 bits. The writer and the reader each use a level handshake driven by strobes. On the write side the writer raises a shift-in strobe while the input-ready output is high. On the read side the reader pulses a shift-out strobe while the output-ready output is high. Storage is a dual-port register array with independent write and read pointers, so a write and a read may land in the same cycle. A word written into an empty buffer falls through to the data output without any read strobe. When the buffer is full, a read reopens the input side, and a shift-in strobe that is still held high is then accepted.

Both strobes are asynchronous to the system clock. Each one passes through a two-stage synchronizer before its edges are detected. The occupancy count includes the word currently shown on the output. Two flags are derived from this count: a half-full flag, and one shared flag that is high near either end of the range (nearly full or nearly empty). An active-low clear empties the buffer. An active-low output enable blanks the data output and reports that it is not driven.

Top module: `ft_fifo`

## Requirements
- R1: While `clear_n` is low, `in_rdy` is 1, `out_rdy` is 0, `dout` is 0, `half_full` is 0 and `edge_near` is 1, with no clock edge needed. The clock edge sampled with `clear_n` low empties the buffer.
- R2: The synchronized `shift_in` is seen high while `in_rdy` is high. The block then stores `din` and drops `in_rdy`. `in_rdy` stays low until `shift_in` is seen low again. It then returns high unless 64 words are held.
- R3: A `shift_in` pulse that begins and ends while `in_rdy` is low stores nothing. When the buffer is full and `shift_in` is held high, the word is stored as soon as a read frees a place.
- R4: A rising `shift_out` while `out_rdy` is high consumes the shown word and drops `out_rdy`. After `shift_out` falls, the next stored word is shown and `out_rdy` rises. If no word is stored, `out_rdy` stays low and `dout` keeps the last word read.
- R5: A `shift_out` pulse while `out_rdy` is low consumes nothing.
- R6: Words leave in the order in which they were written.
- R7: `shift_in` rises just after clock edge 0 into an empty buffer. `in_rdy` is low after edge 3, and the word is on `dout` with `out_rdy` high after edge 4.
- R8: `half_full` is 1 exactly when the count is 32 or more.
- R9: `edge_near` is 1 exactly when the count is 56 or more, or 8 or less.
- R10: The count rises by one on each accepted write and falls by one on each accepted read. A write and a read in the same cycle leave it unchanged. It never exceeds 64.
- R11: With `dout_en_n` high, `dout` is 0 and `dout_oe` is 0. With `dout_en_n` low, `dout_oe` is 1 and `dout` shows the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Active-low clear |
| shift_in | input | 1 | Write strobe, asynchronous |
| din | input | 5 | Write data |
| in_rdy | output | 1 | Buffer can accept a word |
| shift_out | input | 1 | Read strobe, asynchronous |
| out_rdy | output | 1 | `dout` holds a valid unread word |
| dout | output | 5 | Presented word |
| dout_oe | output | 1 | `dout` is driven |
| dout_en_n | input | 1 | Active-low output enable |
| half_full | output | 1 | Count is 32 or more |
| edge_near | output | 1 | Count is 56 or more, or 8 or less |

## Verification
A single write into an empty buffer is timed edge by edge. This separates the synchronizer, capture and presentation stages, and catches any missing or extra register. A fill to 64 words followed by a full drain checks each flag boundary from both directions and checks ordering across pointer wrap. Stray strobes are applied in two places: read pulses on an empty buffer and short write pulses on a full buffer. These tell ignored strobes apart from lost or duplicated words. A write held high against a full buffer, overlapped writes and reads, and a clear applied mid-fill test the reopening of the input, the count rules and the immediate clear.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_SHOW  = 2'd1,
        RD_WAIT  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic ready;
        logic hold;
    } wr_side_t;

    function automatic int half_level(input int depth);
        return depth / 2;
    endfunction

    function automatic int high_level(input int depth);
        return depth - depth / 8;
    endfunction

    function automatic int low_level(input int depth);
        return depth / 8;
    endfunction

endpackage

// File: rtl/ft_strobe_sync.sv
module ft_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic level_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], raw};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/ft_store.sv
module ft_store #(
    parameter  int DATA_W = 5,
    parameter  int DEPTH  = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ft_flags.sv
module ft_flags
    import ft_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic [CW-1:0] level,
    output logic          half,
    output logic          edge_near
);
    localparam int HALF_L = half_level(DEPTH);
    localparam int HIGH_L = high_level(DEPTH);
    localparam int LOW_L  = low_level(DEPTH);

    always_comb begin
        half      = (level >= CW'(HALF_L));
        edge_near = (level >= CW'(HIGH_L)) || (level <= CW'(LOW_L));
    end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
    import ft_fifo_pkg::*;
#(
    parameter int DATA_W = 5,
    parameter int DEPTH  = 64,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              shift_in,
    input  logic [DATA_W-1:0] din,
    output logic              in_rdy,
    input  logic              shift_out,
    output logic              out_rdy,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic              dout_en_n,
    output logic              half_full,
    output logic              edge_near
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic rst;
    assign rst = ~clear_n;

    // strobe synchronizers
    logic si_lvl, si_lvl_d, so_lvl, so_lvl_d;

    ft_strobe_sync #(.STAGES(SYNC_N)) u_si_sync (
        .clk(clk), .rst(rst), .raw(shift_in), .level(si_lvl), .level_d(si_lvl_d)
    );
    ft_strobe_sync #(.STAGES(SYNC_N)) u_so_sync (
        .clk(clk), .rst(rst), .raw(shift_out), .level(so_lvl), .level_d(so_lvl_d)
    );

    logic si_fall, so_rise, so_fall;
    assign si_fall = ~si_lvl & si_lvl_d;
    assign so_rise = so_lvl & ~so_lvl_d;
    assign so_fall = ~so_lvl & so_lvl_d;

    // state
    logic [AW:0]       wptr_q, rptr_q;
    logic [CW-1:0]     cnt_q, cnt_nx;
    wr_side_t          wr_q, wr_nx;
    rd_state_e         rd_q, rd_nx;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] rd_word;

    logic wr_acc, rd_acc, mem_has, load;

    assign wr_acc  = wr_q.ready & si_lvl;
    assign rd_acc  = (rd_q == RD_SHOW) & so_rise;
    assign mem_has = (wptr_q != rptr_q);
    assign load    = (rd_q == RD_EMPTY) & mem_has;

    ft_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wptr_q[AW-1:0]),
        .wdata (din),
        .raddr (rptr_q[AW-1:0]),
        .rdata (rd_word)
    );

    // count and write-side next state
    always_comb begin
        cnt_nx = cnt_q + CW'(wr_acc) - CW'(rd_acc);
        wr_nx.hold = wr_q.hold;
        if (wr_acc) begin
            wr_nx.hold = 1'b1;
        end else if (si_fall) begin
            wr_nx.hold = 1'b0;
        end
        wr_nx.ready = ~wr_nx.hold && (cnt_nx != CW'(DEPTH));
    end

    // read-side next state
    always_comb begin
        rd_nx = rd_q;
        unique case (rd_q)
            RD_EMPTY: if (load)    rd_nx = RD_SHOW;
            RD_SHOW:  if (so_rise) rd_nx = RD_WAIT;
            RD_WAIT:  if (so_fall) rd_nx = RD_EMPTY;
            default:               rd_nx = RD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            wr_q   <= '{ready: 1'b1, hold: 1'b0};
            rd_q   <= RD_EMPTY;
            dout_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
            wr_q  <= wr_nx;
            rd_q  <= rd_nx;
            if (wr_acc) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (load) begin
                rptr_q <= rptr_q + 1'b1;
                dout_q <= rd_word;
            end
        end
    end

    // flags
    logic hf_raw, edge_raw;

    ft_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .level     (cnt_q),
        .half      (hf_raw),
        .edge_near (edge_raw)
    );

    // outputs, clear overrides without waiting for a clock
    assign in_rdy    = rst | wr_q.ready;
    assign out_rdy   = clear_n & (rd_q == RD_SHOW);
    assign dout      = (clear_n & ~dout_en_n) ? dout_q : '0;
    assign dout_oe   = ~dout_en_n;
    assign half_full = clear_n & hf_raw;
    assign edge_near = rst | edge_raw;
endmodule

module ft_fifo_chk #(
    parameter int DATA_W = 5,
    parameter int DEPTH  = 64,
    parameter int CW     = 7
) (
    input logic              clk,
    input logic              clear_n,
    input logic              in_rdy,
    input logic              out_rdy,
    input logic [DATA_W-1:0] dout,
    input logic              half_full,
    input logic [CW-1:0]     cnt,
    input logic [DATA_W-1:0] word_q
);
    // R1: clear forces the empty view at once
    assert_clear_view_R1: assert property (@(posedge clk)
        !clear_n |-> (in_rdy && !out_rdy && dout == '0 && !half_full));

    // R3: a full buffer never offers input
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!clear_n)
        (cnt == CW'(DEPTH)) |-> !in_rdy);

    // R10: count moves by at most one per cycle and stays in range
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!clear_n)
        (cnt <= CW'(DEPTH)) &&
        ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || ($past(cnt) == cnt + 1'b1)));

    // R4: presented word only changes together with a fresh presentation
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!clear_n)
        !$stable(word_q) |-> out_rdy);

    // R4: a shown word is counted
    assert_shown_counted_R4: assert property (@(posedge clk) disable iff (!clear_n)
        out_rdy |-> (cnt != '0));

    // R8: half flag rises exactly at the half level
    assert_half_rise_R8: assert property (@(posedge clk) disable iff (!clear_n)
        $rose(half_full) |-> (cnt == CW'(DEPTH / 2)));
endmodule

bind ft_fifo ft_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .dout      (dout),
    .half_full (half_full),
    .cnt       (cnt_q),
    .word_q    (dout_q)
);

// File: tb/ft_fifo_tb.sv
`timescale 1ns/1ps
module ft_fifo_tb;
    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       shift_in = 1'b0;
    logic [4:0] din = '0;
    logic       in_rdy;
    logic       shift_out = 1'b0;
    logic       out_rdy;
    logic [4:0] dout;
    logic       dout_oe;
    logic       dout_en_n = 1'b0;
    logic       half_full;
    logic       edge_near;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [4:0] qref[$];
    logic [4:0] last_out = '0;

    always #2 clk = ~clk;

    ft_fifo u_dut (
        .clk(clk), .clear_n(clear_n), .shift_in(shift_in), .din(din), .in_rdy(in_rdy),
        .shift_out(shift_out), .out_rdy(out_rdy), .dout(dout), .dout_oe(dout_oe),
        .dout_en_n(dout_en_n), .half_full(half_full), .edge_near(edge_near)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_in(input logic want);
        int t = 0;
        while (in_rdy !== want && t < 400) begin @(negedge clk); t++; end
        if (t >= 400) chk("R2 in_rdy timeout", int'(in_rdy), int'(want));
    endtask

    task automatic wait_out(input logic want);
        int t = 0;
        while (out_rdy !== want && t < 400) begin @(negedge clk); t++; end
        if (t >= 400) chk("R4 out_rdy timeout", int'(out_rdy), int'(want));
    endtask

    task automatic push(input logic [4:0] w);
        wait_in(1'b1);
        din = w;
        shift_in = 1'b1;
        wait_in(1'b0);
        shift_in = 1'b0;
        qref.push_back(w);
        repeat (3) @(negedge clk);
    endtask

    task automatic pop();
        logic [4:0] exp;
        wait_out(1'b1);
        exp = qref.pop_front();
        chk("R6 order", int'(dout), int'(exp));
        last_out = exp;
        shift_out = 1'b1;
        wait_out(1'b0);
        shift_out = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_flags(input string tag);
        int n = qref.size();
        chk({"R8 half_full ", tag}, int'(half_full), int'(n >= 32));
        chk({"R9 edge_near ", tag}, int'(edge_near), int'(n >= 56 || n <= 8));
    endtask

    task automatic t_reset();
        chk("R1 in_rdy after clear", int'(in_rdy), 1);
        chk("R1 out_rdy after clear", int'(out_rdy), 0);
        chk("R1 dout after clear", int'(dout), 0);
        chk("R1 half_full after clear", int'(half_full), 0);
        chk("R1 edge_near after clear", int'(edge_near), 1);
    endtask

    task automatic t_fall_through();
        int n = 0;
        int ir_at = 0;
        @(negedge clk);
        din = 5'd22;
        shift_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!in_rdy && ir_at == 0) ir_at = n;
            if (out_rdy) break;
        end
        chk("R7 in_rdy low edge", ir_at, 3);
        chk("R7 out_rdy high edge", n, 4);
        chk("R7 fall-through word", int'(dout), 22);
        qref.push_back(5'd22);
        repeat (6) @(negedge clk);
        chk("R2 in_rdy held low while strobe high", int'(in_rdy), 0);
        shift_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 in_rdy back high", int'(in_rdy), 1);
        pop();
        repeat (4) @(negedge clk);
        chk("R2 single capture", int'(out_rdy), 0);
    endtask

    task automatic t_order_and_hold();
        push(5'd1); push(5'd30); push(5'd0); push(5'd17); push(5'd9);
        for (int i = 0; i < 5; i++) pop();
        chk("R4 out_rdy low when drained", int'(out_rdy), 0);
        chk("R4 last word kept", int'(dout), int'(last_out));
    endtask

    task automatic t_stray_read();
        shift_out = 1'b1;
        repeat (4) @(negedge clk);
        shift_out = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 stray read leaves empty", int'(out_rdy), 0);
        push(5'd13);
        chk("R5 word after stray read", int'(dout), 13);
        chk("R5 shown after stray read", int'(out_rdy), 1);
        pop();
    endtask

    task automatic t_fill_drain();
        for (int i = 1; i <= 64; i++) begin
            push(5'((i * 7 + 3) % 32));
            if (i == 8 || i == 9 || i == 31 || i == 32 || i == 55 || i == 56 || i == 64)
                chk_flags($sformatf("fill %0d", i));
        end
        chk("R2 full keeps in_rdy low", int'(in_rdy), 0);
        din = 5'd31;
        shift_in = 1'b1;
        repeat (4) @(negedge clk);
        shift_in = 1'b0;
        repeat (6) @(negedge clk);
        din = 5'd6;
        shift_in = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 held strobe blocked while full", int'(in_rdy), 0);
        pop();
        repeat (8) @(negedge clk);
        qref.push_back(5'd6);
        chk("R3 held word taken after read", int'(in_rdy), 0);
        shift_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 full again after held write", int'(in_rdy), 0);
        while (qref.size() > 0) begin
            pop();
            if (qref.size() == 56 || qref.size() == 55 || qref.size() == 32 ||
                qref.size() == 31 || qref.size() == 9 || qref.size() == 8)
                chk_flags($sformatf("drain %0d", qref.size()));
        end
        chk("R3 stray short pulse stored nothing", int'(out_rdy), 0);
        chk("R4 last word kept after drain", int'(dout), 6);
    endtask

    task automatic t_simultaneous();
        push(5'd3); push(5'd4); push(5'd5);
        fork
            push(5'd11);
            pop();
        join
        chk_flags("R10 after overlap");
        while (qref.size() > 0) pop();
        chk("R10 empty after overlap drain", int'(out_rdy), 0);
    endtask

    task automatic t_enable();
        push(5'd25);
        dout_en_n = 1'b1;
        @(negedge clk);
        chk("R11 dout blanked", int'(dout), 0);
        chk("R11 dout_oe low", int'(dout_oe), 0);
        dout_en_n = 1'b0;
        @(negedge clk);
        chk("R11 dout restored", int'(dout), 25);
        chk("R11 dout_oe high", int'(dout_oe), 1);
        pop();
    endtask

    task automatic t_clear_mid();
        for (int i = 0; i < 12; i++) push(5'(i + 2));
        @(negedge clk);
        clear_n = 1'b0;
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        clear_n = 1'b1;
        qref.delete();
        repeat (2) @(negedge clk);
        t_reset();
        push(5'd19);
        chk("R1 usable after clear", int'(dout), 19);
        pop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        clear_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_fall_through();
        t_order_and_hold();
        t_stray_read();
        t_fill_drain();
        t_simultaneous();
        t_enable();
        t_clear_mid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule